// File: doc/BRIEF.md
# Memory Window Decoder with Locked Start-Up Mode

This block sits on the slave side of a simple SRAM-style bus. It decodes an 8KB window into four equal 2KB sections. The first two sections serve the two 64-byte halves of a boot ROM. Each half repeats throughout its section, so a host that scans for expansion ROMs finds valid code at every 64-byte boundary. The third section holds a small control register bank. The fourth section passes reads and writes straight through to a flash data window.

The block tracks a two-state operating mode. After power-on it is locked. While locked, every read returns boot ROM bytes, whatever the section, and every write is dropped. The only writes that count are the ones that make up the unlock sequence on the control register. That sequence is a fixed key byte followed at once by its bitwise complement. A host in the open mode can lock the block again by writing the control register with its lowest bit set. An external boot-detect pulse opens the block in one step.

Accesses are single-cycle strobes. Read data returns one cycle later, together with a valid flag. The ROM contents and the flash array live outside the block and are reached through side ports.

Top module: `mem_window_decoder`

## Requirements
- R1: Address bits [12:11] select the section: 0 and 1 are the low and high boot halves, 2 is the register bank, 3 is the flash window.
- R2: A read of section 0 or 1 returns the ROM byte at index {addr[11], addr[5:0]}. Address bits [10:6] have no effect, so each 64-byte half repeats 32 times.
- R3: A read cycle is bus_sel=1, bus_rd=1, bus_wr=0. Its data appears on bus_rdata with bus_rvalid=1 in the next cycle. When bus_rd and bus_wr are both high, the cycle is a write only, and bus_rvalid stays low.
- R4: After reset the block is locked and mode_normal is 0. While locked, a read of any section returns the ROM byte at {addr[11], addr[5:0]}, and the flash strobes stay low.
- R5: While locked, writes have no effect. No flash write strobe is issued, and the bank registers keep their contents.
- R6: The control register is section 2 with addr[1:0]=0. While locked, a write of 0xA5 to it, followed by a write of 0x5A to it as the very next write, opens the block in the cycle after the second write. Any other write in between restarts the sequence, and a fresh 0xA5 arms it again.
- R7: While open, a control write with bit 0 set locks the block from the next cycle on. A control write with bit 0 clear leaves the mode as it is.
- R8: A boot_trig pulse opens the block in the next cycle. It has priority over a simultaneous control write.
- R9: While open, section 2 registers at indices 1 to 3 (addr[1:0]) store written bytes and read them back, aliased through the section. The control register reads 0x00.
- R10: While open, a section 3 access drives fl_rd or fl_wr in the same cycle, with fl_addr = addr[10:0] and fl_wdata = the write data. A read returns fl_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Window select, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | bus_rdata is valid this cycle |
| boot_trig | input | 1 | Boot-detect pulse, opens the block |
| mode_normal | output | 1 | 1 when open, 0 when locked |
| rom_addr | output | 7 | Boot ROM byte index |
| rom_data | input | 8 | Boot ROM byte, combinational |
| fl_rd | output | 1 | Flash window read strobe |
| fl_wr | output | 1 | Flash window write strobe |
| fl_addr | output | 11 | Offset within the flash window |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, combinational |

## Verification
The assertions check several rules on every cycle:
- the mode transitions: the unlock completion, staying locked when no complement follows an armed key, boot-detect priority, and re-locking;
- that no flash strobe fires while locked;
- that the bank registers hold still while locked;
- the one-cycle read-valid timing and the confinement of flash strobes to section 3.

Only the bench scenarios can show the following:
- the data values of the boot-byte aliasing pattern;
- that an interrupting write, or a repeated key, restarts the unlock sequence;
- that a write made while locked leaves no trace once the block is opened;
- register readback through aliased addresses.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
   typedef enum logic {
      MODE_LOCKED = 1'b0,
      MODE_OPEN   = 1'b1
   } mode_e;

   typedef enum logic [1:0] {
      SEC_BOOT_LO = 2'd0,
      SEC_BOOT_HI = 2'd1,
      SEC_REGS    = 2'd2,
      SEC_FLASH   = 2'd3
   } sec_e;
endpackage

// File: rtl/mwd_sec_decode.sv
module mwd_sec_decode
   import mwd_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int BOOT_AW = 6,
   parameter int REG_AW  = 2
) (
   input  logic [ADDR_W-1:0]  addr,
   output sec_e               sec,
   output logic [BOOT_AW:0]   rom_idx,
   output logic [ADDR_W-3:0]  win_off,
   output logic [REG_AW-1:0]  reg_idx
);
   localparam int SEC_AW = ADDR_W - 2;

   generate
      if (BOOT_AW >= SEC_AW) begin : g_bad_boot
         $error("boot half must be smaller than a section");
      end
      if (REG_AW < 1 || REG_AW >= SEC_AW) begin : g_bad_reg
         $error("register index width out of range");
      end
   endgenerate

   // top two address bits pick the section; lsb of the section picks the boot half
   assign sec     = sec_e'(addr[ADDR_W-1 -: 2]);
   assign rom_idx = {addr[SEC_AW], addr[BOOT_AW-1:0]};
   assign win_off = addr[SEC_AW-1:0];
   assign reg_idx = addr[REG_AW-1:0];
endmodule

// File: rtl/mwd_mode_ctrl.sv
module mwd_mode_ctrl
   import mwd_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_wr,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              boot_trig,
   output mode_e             mode,
   output logic              armed
);
   localparam logic [DATA_W-1:0] KEY_INV = ~UNLOCK_KEY;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("data width too small for the unlock key");
      end
   endgenerate

   mode_e mode_q;
   logic  armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_LOCKED;
         armed_q <= 1'b0;
      end else if (boot_trig) begin
         mode_q  <= MODE_OPEN;
         armed_q <= 1'b0;
      end else if (mode_q == MODE_LOCKED) begin
         if (any_wr) begin
            if (ctrl_wr && armed_q && wdata == KEY_INV) begin
               mode_q  <= MODE_OPEN;
               armed_q <= 1'b0;
            end else begin
               armed_q <= ctrl_wr && (wdata == UNLOCK_KEY);
            end
         end
      end else begin
         armed_q <= 1'b0;
         if (ctrl_wr && wdata[0]) mode_q <= MODE_LOCKED;
      end
   end

   assign mode  = mode_q;
   assign armed = armed_q;

   // R6: complement after an armed key opens the block
   assert_unlock_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LOCKED && armed_q && ctrl_wr && wdata == KEY_INV) |=> mode_q == MODE_OPEN);
   // R6: without an armed complement write the block stays locked
   assert_stay_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LOCKED && !boot_trig && !(armed_q && ctrl_wr)) |=> mode_q == MODE_LOCKED);
   assert_armed_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> mode_q == MODE_LOCKED);
   // R8: boot-detect wins
   assert_trig_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
      boot_trig |=> mode_q == MODE_OPEN);
   // R7: relock
   assert_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OPEN && ctrl_wr && wdata[0] && !boot_trig) |=> mode_q == MODE_LOCKED);
endmodule

// File: rtl/mwd_reg_bank.sv
module mwd_reg_bank #(
   parameter int DATA_W = 8,
   parameter int REG_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int REG_N = 1 << REG_AW;

   generate
      if (REG_N > 256) begin : g_bad_depth
         $error("register bank too deep");
      end
   endgenerate

   // slot 0 is the control register: no storage, reads as zero
   logic [REG_N-1:0][DATA_W-1:0] regs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (wr_en && idx != '0) begin
         regs_q[idx] <= wdata;
      end
   end

   assign rdata = regs_q[idx];

   // R5: bank contents frozen while locked
   assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(regs_q));
   assert_locked_no_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !wr_en);
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
   import mwd_pkg::*;
#(
   parameter int                ADDR_W     = 13,
   parameter int                DATA_W     = 8,
   parameter int                BOOT_AW    = 6,
   parameter int                REG_AW     = 2,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   input  logic              boot_trig,
   output logic              mode_normal,
   output logic [BOOT_AW:0]  rom_addr,
   input  logic [DATA_W-1:0] rom_data,
   output logic              fl_rd,
   output logic              fl_wr,
   output logic [ADDR_W-3:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   input  logic [DATA_W-1:0] fl_rdata
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("address too narrow for four sections");
      end
   endgenerate

   sec_e              sec;
   logic [REG_AW-1:0] reg_idx;
   logic [ADDR_W-3:0] win_off;
   mode_e             mode;
   logic              armed;
   logic [DATA_W-1:0] reg_rdata;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   wire wr_cyc  = bus_sel & bus_wr;
   wire rd_cyc  = bus_sel & bus_rd & ~bus_wr;
   wire is_open = (mode == MODE_OPEN);
   wire in_regs = (sec == SEC_REGS);
   wire ctrl_wr = wr_cyc & in_regs & (reg_idx == '0);
   wire reg_wr  = wr_cyc & is_open & in_regs;

   mwd_sec_decode #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .REG_AW(REG_AW)) u_dec (
      .addr    (bus_addr),
      .sec     (sec),
      .rom_idx (rom_addr),
      .win_off (win_off),
      .reg_idx (reg_idx)
   );

   mwd_mode_ctrl #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_wr    (wr_cyc),
      .ctrl_wr   (ctrl_wr),
      .wdata     (bus_wdata),
      .boot_trig (boot_trig),
      .mode      (mode),
      .armed     (armed)
   );

   mwd_reg_bank #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .locked (~is_open),
      .wr_en  (reg_wr),
      .idx    (reg_idx),
      .wdata  (bus_wdata),
      .rdata  (reg_rdata)
   );

   assign fl_rd    = rd_cyc & is_open & (sec == SEC_FLASH);
   assign fl_wr    = wr_cyc & is_open & (sec == SEC_FLASH);
   assign fl_addr  = win_off;
   assign fl_wdata = bus_wdata;

   always_comb begin
      rd_mux = rom_data;
      if (is_open) begin
         unique case (sec)
            SEC_REGS:  rd_mux = reg_rdata;
            SEC_FLASH: rd_mux = fl_rdata;
            default:   rd_mux = rom_data;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_cyc;
         if (rd_cyc) rdata_q <= rd_mux;
      end
   end

   assign bus_rdata   = rdata_q;
   assign bus_rvalid  = rvalid_q;
   assign mode_normal = is_open;

   // R4 / R5: no flash traffic while locked
   assert_no_flash_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_normal |-> !(fl_wr || fl_rd));
   // R10: flash strobes only in section 3
   assert_flash_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_wr || fl_rd) |-> bus_addr[ADDR_W-1 -: 2] == 2'b11);
   // R3: read data valid exactly one cycle after a read cycle
   assert_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_rd && !bus_wr) |=> bus_rvalid);
   assert_no_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_rd && !bus_wr) |=> !bus_rvalid);
   assert_armed_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !mode_normal);
endmodule

// File: tb/mem_window_decoder_bench.sv
module mem_window_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_rvalid;
   logic        boot_trig = 1'b0;
   logic        mode_normal;
   logic [6:0]  rom_addr;
   logic [7:0]  rom_data;
   logic        fl_rd, fl_wr;
   logic [10:0] fl_addr;
   logic [7:0]  fl_wdata;
   logic [7:0]  fl_rdata;

   int checks = 0;
   int fails  = 0;
   int fl_wr_cnt = 0;
   int fl_rd_cnt = 0;
   logic [10:0] last_fw_addr = '0;
   logic [7:0]  last_fw_data = '0;

   always #4 clk = ~clk;

   function automatic logic [7:0] rom_fn(input logic [6:0] a);
      return 8'({1'b0, a} * 8'd5 + 8'd3);
   endfunction

   function automatic logic [7:0] fl_fn(input logic [10:0] a);
      return a[7:0] ^ {5'b0, a[10:8]} ^ 8'h96;
   endfunction

   assign rom_data = rom_fn(rom_addr);
   assign fl_rdata = fl_fn(fl_addr);

   always @(posedge clk) begin
      if (fl_wr) begin
         fl_wr_cnt++;
         last_fw_addr = fl_addr;
         last_fw_data = fl_wdata;
      end
      if (fl_rd) fl_rd_cnt++;
   end

   mem_window_decoder u_mem_window_decoder (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .boot_trig(boot_trig), .mode_normal(mode_normal),
      .rom_addr(rom_addr), .rom_data(rom_data), .fl_rd(fl_rd), .fl_wr(fl_wr),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [12:0] a, output logic [7:0] d, output logic v);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
      d = bus_rdata;
      v = bus_rvalid;
   endtask

   task automatic read_expect(input string req, input logic [12:0] a, input logic [7:0] exp);
      logic [7:0] d;
      logic v;
      bus_read(a, d, v);
      chk(req, {31'b0, v}, 32'd1);
      chk(req, {24'b0, d}, {24'b0, exp});
   endtask

   task automatic unlock();
      bus_write(13'h1000, 8'hA5);
      bus_write(13'h1000, 8'h5A);
   endtask

   task automatic t_reset_state();
      chk("R4 mode after reset", {31'b0, mode_normal}, 32'd0);
      chk("R3 rvalid idle", {31'b0, bus_rvalid}, 32'd0);
      chk("R4 flash strobes idle", {30'b0, fl_rd, fl_wr}, 32'd0);
   endtask

   task automatic t_locked_reads();
      int rd0;
      rd0 = fl_rd_cnt;
      read_expect("R4 locked sec0", 13'h0005, rom_fn(7'h05));
      read_expect("R4 locked sec1", 13'h0FC5, rom_fn(7'h45));
      read_expect("R4 locked sec2", 13'h1005, rom_fn(7'h05));
      read_expect("R4 locked sec3", 13'h1845, rom_fn(7'h45));
      chk("R4 no flash read locked", rd0, fl_rd_cnt);
   endtask

   task automatic t_locked_writes();
      int wr0;
      wr0 = fl_wr_cnt;
      bus_write(13'h1800, 8'h11);
      bus_write(13'h1001, 8'h77);
      chk("R5 no flash write locked", wr0, fl_wr_cnt);
      chk("R5 still locked", {31'b0, mode_normal}, 32'd0);
   endtask

   task automatic t_unlock_sequence();
      bus_write(13'h1000, 8'hA5);
      bus_write(13'h1802, 8'h00);
      bus_write(13'h1000, 8'h5A);
      chk("R6 interrupted sequence stays locked", {31'b0, mode_normal}, 32'd0);
      bus_write(13'h1000, 8'h5A);
      chk("R6 complement alone stays locked", {31'b0, mode_normal}, 32'd0);
      bus_write(13'h1004, 8'hA5);
      bus_write(13'h17F8, 8'h5A);
      chk("R6 aliased unlock opens", {31'b0, mode_normal}, 32'd1);
   endtask

   task automatic t_regs();
      read_expect("R5 locked write left no trace", 13'h1001, 8'h00);
      bus_write(13'h1001, 8'h3C);
      bus_write(13'h1002, 8'hC3);
      bus_write(13'h1003, 8'h99);
      read_expect("R9 reg1", 13'h1001, 8'h3C);
      read_expect("R9 reg2", 13'h1002, 8'hC2 ^ 8'h01);
      read_expect("R9 reg3 aliased", 13'h17FB, 8'h99);
      read_expect("R9 reg1 aliased", 13'h17F9, 8'h3C);
      read_expect("R9 control reads zero", 13'h1000, 8'h00);
   endtask

   task automatic t_boot_open();
      read_expect("R2 bit6 ignored", 13'h0045, rom_fn(7'h05));
      read_expect("R2 top of sec0", 13'h07FF, rom_fn(7'h3F));
      read_expect("R1 start of sec1", 13'h0800, rom_fn(7'h40));
      read_expect("R2 sec1 alias", 13'h0FC1, rom_fn(7'h41));
   endtask

   task automatic t_flash();
      int rd0;
      int wr0;
      rd0 = fl_rd_cnt;
      read_expect("R10 flash read", 13'h1ABC, fl_fn(11'h2BC));
      chk("R10 one flash read strobe", fl_rd_cnt, rd0 + 1);
      wr0 = fl_wr_cnt;
      bus_write(13'h1812, 8'h5E);
      chk("R10 flash write count", fl_wr_cnt, wr0 + 1);
      chk("R10 flash write addr", {21'b0, last_fw_addr}, 32'h012);
      chk("R10 flash write data", {24'b0, last_fw_data}, 32'h5E);
   endtask

   task automatic t_rd_wr_both();
      int wr0;
      wr0 = fl_wr_cnt;
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 13'h1820; bus_wdata = 8'h44;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
      chk("R3 both strobes: no rvalid", {31'b0, bus_rvalid}, 32'd0);
      chk("R3 both strobes: write done", fl_wr_cnt, wr0 + 1);
   endtask

   task automatic t_relock();
      bus_write(13'h1000, 8'h02);
      chk("R7 bit0 clear keeps open", {31'b0, mode_normal}, 32'd1);
      bus_write(13'h1000, 8'h01);
      chk("R7 bit0 set locks", {31'b0, mode_normal}, 32'd0);
      read_expect("R4 relocked sec3 gives boot", 13'h1801, rom_fn(7'h41));
      bus_write(13'h1000, 8'hA5);
      bus_write(13'h1000, 8'hA5);
      bus_write(13'h1000, 8'h5A);
      chk("R6 repeated key rearms", {31'b0, mode_normal}, 32'd1);
   endtask

   task automatic t_boot_trig();
      bus_write(13'h1000, 8'h01);
      chk("R8 precondition locked", {31'b0, mode_normal}, 32'd0);
      @(negedge clk);
      boot_trig = 1'b1;
      @(negedge clk);
      boot_trig = 1'b0;
      chk("R8 trigger opens", {31'b0, mode_normal}, 32'd1);
      @(negedge clk);
      boot_trig = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 13'h1000; bus_wdata = 8'h01;
      @(negedge clk);
      boot_trig = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      chk("R8 trigger beats relock", {31'b0, mode_normal}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_locked_reads();
      t_locked_writes();
      t_unlock_sequence();
      t_regs();
      t_boot_open();
      t_flash();
      t_rd_wr_both();
      t_relock();
      t_boot_trig();
      unlock();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule